// File: doc/BRIEF.md
# Multi-Master Doorbell Interrupt Unit

This block holds a row of doorbell channels, one for each receiving master in a system. A source master rings a target by writing to that target's trigger register. Every write on the register bus carries the writer's master ID, and the ring is recorded under that ID. A target chooses which sources may interrupt it through its own enable mask. The target then sees which sources rang in a write-one-to-clear pending vector, rather than in a single flag.

Each channel keeps two state vectors. The raw vector logs every ring, whether or not it is enabled. The enable vector filters the raw vector into the pending view, and any pending bit drives that channel's interrupt line. Several write ports can act in the same cycle, so a source can ring while the target clears. A ring and a clear of the same bit resolve so that the ring is kept. Reads go through a single port and return data one cycle after the request.

Top module: `dbell_unit`

## Requirements
- R1: After reset every enable and raw vector is zero, so every pending vector reads zero and every interrupt output is low.
- R2: Channel c occupies the 256-byte window starting at c*0x100. Within the window the registers sit at 0x0 (trigger), 0x4 (enable), 0x8 (raw) and 0xC (pending). Any other offset bits, or a channel index of NUM_DB or more, address nothing. A read returns its data on `rd_data_o` with `rd_valid_o` high in the cycle after `rd_en_i`. Trigger, unmapped addresses and bits above NUM_MASTERS read as zero.
- R3: A trigger write with data bit 0 set sets raw bit m of that channel, where m is the writer's master ID. A trigger write with data bit 0 clear changes nothing.
- R4: The raw vector records a ring whether or not its source is enabled. The pending vector reads as raw AND enable.
- R5: The interrupt output irq_o[c] is high exactly when channel c has any pending bit set. It rises right after the clock edge that records an enabled ring, and it stays high until every pending bit is cleared.
- R6: Enabling a source whose raw bit is already set makes that bit pending, and it raises the interrupt right after the enable write's clock edge.
- R7: Writing to the pending register clears each raw bit whose data bit is 1 and leaves the raw bits under data bits of 0 unchanged.
- R8: When a ring and a clear of the same bit arrive in the same cycle on different ports, the bit ends up set.
- R9: The enable register is read/write and a write replaces the whole mask. When several ports write the same enable register in one cycle, the lowest-numbered port's data is kept.
- R10: Writes to the raw register, and writes to unmapped addresses, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | NUM_WP | Write strobe, one per port |
| wr_addr_i | input | NUM_WP*ADDR_W | Byte address, port p in slice p |
| wr_data_i | input | NUM_WP*DATA_W | Write data, port p in slice p |
| wr_mid_i | input | NUM_WP*MID_W | Writer master ID, port p in slice p |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read byte address |
| rd_data_o | output | DATA_W | Read data, one cycle after the strobe |
| rd_valid_o | output | 1 | Read data valid |
| irq_o | output | NUM_DB | Interrupt, one per doorbell channel |

## Verification
A raw bit that is lost or set without a ring first shows up on the interrupt line of its channel, and it does so immediately after the offending clock edge, but only if that source is enabled. Otherwise the error stays hidden until the raw register is read back. For that reason, each scenario reads both raw and pending, and the full interrupt vector is compared after every write. A wrong enable mask shows up as an interrupt that appears or disappears in the cycle after the enable write, and the bench checks for this by enabling sources that were latched earlier and by having two ports write the same mask at once.

// File: rtl/dbu_pkg.sv
package dbu_pkg;
   localparam int CH_SHIFT = 8;

   typedef enum logic [1:0] {
      K_TRIG = 2'd0,
      K_EN   = 2'd1,
      K_RAW  = 2'd2,
      K_PEND = 2'd3
   } reg_kind_e;
endpackage

// File: rtl/dbu_wdec.sv
module dbu_wdec #(
   parameter int NUM_DB      = 4,
   parameter int NUM_MASTERS = 32,
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   parameter int MID_W       = 5
) (
   input  logic                                   we_i,
   input  logic [ADDR_W-1:0]                      addr_i,
   input  logic [DATA_W-1:0]                      data_i,
   input  logic [MID_W-1:0]                       mid_i,
   output logic [NUM_DB-1:0][NUM_MASTERS-1:0]     ring_o,
   output logic [NUM_DB-1:0][NUM_MASTERS-1:0]     clr_o,
   output logic [NUM_DB-1:0]                      en_we_o
);
   import dbu_pkg::*;

   localparam int CH_W = ADDR_W - CH_SHIFT;

   logic [CH_W-1:0]        chan;
   reg_kind_e              kind;
   logic                   ok;
   logic                   mid_ok;
   logic [NUM_MASTERS-1:0] src_1h;

   always_comb begin
      chan   = addr_i[ADDR_W-1:CH_SHIFT];
      kind   = reg_kind_e'(addr_i[3:2]);
      ok     = we_i && (addr_i[CH_SHIFT-1:4] == '0) && (addr_i[1:0] == 2'b00)
               && (int'(chan) < NUM_DB);
      mid_ok = int'(mid_i) < NUM_MASTERS;
      src_1h = '0;
      if (mid_ok) src_1h[mid_i] = 1'b1;
   end

   for (genvar c = 0; c < NUM_DB; c++) begin : g_ch
      logic sel;
      assign sel        = ok && (int'(chan) == c);
      assign ring_o[c]  = (sel && kind == K_TRIG && data_i[0]) ? src_1h : '0;
      assign clr_o[c]   = (sel && kind == K_PEND) ? data_i[NUM_MASTERS-1:0] : '0;
      assign en_we_o[c] = sel && kind == K_EN;
   end
endmodule

// File: rtl/dbu_chan.sv
module dbu_chan #(
   parameter int NUM_MASTERS = 32,
   parameter int NUM_WP      = 2
) (
   input  logic                                 clk_i,
   input  logic                                 rst_ni,
   input  logic [NUM_WP-1:0][NUM_MASTERS-1:0]   ring_i,
   input  logic [NUM_WP-1:0][NUM_MASTERS-1:0]   clr_i,
   input  logic [NUM_WP-1:0]                    en_we_i,
   input  logic [NUM_WP-1:0][NUM_MASTERS-1:0]   en_data_i,
   output logic [NUM_MASTERS-1:0]               en_o,
   output logic [NUM_MASTERS-1:0]               raw_o,
   output logic                                 irq_o
);
   logic [NUM_MASTERS-1:0] en_q, raw_q, en_d, raw_d;
   logic [NUM_MASTERS-1:0] ring_all, clr_all;
   logic                   any_en_we;

   always_comb begin
      ring_all = '0;
      clr_all  = '0;
      for (int p = 0; p < NUM_WP; p++) begin
         ring_all |= ring_i[p];
         clr_all  |= clr_i[p];
      end
      any_en_we = |en_we_i;
      en_d = en_q;
      for (int p = NUM_WP - 1; p >= 0; p--) begin
         if (en_we_i[p]) en_d = en_data_i[p];
      end
      raw_d = (raw_q & ~clr_all) | ring_all;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q  <= '0;
         raw_q <= '0;
      end else begin
         en_q  <= en_d;
         raw_q <= raw_d;
      end
   end

   assign en_o  = en_q;
   assign raw_o = raw_q;
   assign irq_o = |(raw_q & en_q);

   // R3, R8: every ring of the previous cycle is latched
   p_ring_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((raw_q & $past(ring_all)) == $past(ring_all)));

   // R7: a clear without a competing ring empties the bit
   p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((raw_q & $past(clr_all & ~ring_all)) == '0));

   // R4: no raw bit rises without a ring
   p_no_spont_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(ring_all)) == '0));

   // R5: interrupt holds while no clear arrives
   p_irq_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && clr_all == '0 && !any_en_we) |=> irq_o);

   // R9: enable changes only on an enable write
   p_en_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !any_en_we |=> $stable(en_q));
endmodule

// File: rtl/dbu_rdmux.sv
module dbu_rdmux #(
   parameter int NUM_DB      = 4,
   parameter int NUM_MASTERS = 32,
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32
) (
   input  logic                                 clk_i,
   input  logic                                 rst_ni,
   input  logic                                 rd_en_i,
   input  logic [ADDR_W-1:0]                    rd_addr_i,
   input  logic [NUM_DB-1:0][NUM_MASTERS-1:0]   en_i,
   input  logic [NUM_DB-1:0][NUM_MASTERS-1:0]   raw_i,
   output logic [DATA_W-1:0]                    rd_data_o,
   output logic                                 rd_valid_o
);
   import dbu_pkg::*;

   localparam int CH_W = ADDR_W - CH_SHIFT;

   logic [CH_W-1:0]        chan;
   reg_kind_e              kind;
   logic                   ok;
   logic [NUM_MASTERS-1:0] sel_en, sel_raw, word;
   logic [DATA_W-1:0]      data_d;

   always_comb begin
      chan    = rd_addr_i[ADDR_W-1:CH_SHIFT];
      kind    = reg_kind_e'(rd_addr_i[3:2]);
      ok      = (rd_addr_i[CH_SHIFT-1:4] == '0) && (rd_addr_i[1:0] == 2'b00)
                && (int'(chan) < NUM_DB);
      sel_en  = '0;
      sel_raw = '0;
      for (int c = 0; c < NUM_DB; c++) begin
         if (int'(chan) == c) begin
            sel_en  = en_i[c];
            sel_raw = raw_i[c];
         end
      end
      unique case (kind)
         K_EN:    word = sel_en;
         K_RAW:   word = sel_raw;
         K_PEND:  word = sel_raw & sel_en;
         default: word = '0;
      endcase
      data_d = '0;
      if (ok) data_d[NUM_MASTERS-1:0] = word;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_data_o  <= '0;
         rd_valid_o <= 1'b0;
      end else begin
         rd_valid_o <= rd_en_i;
         rd_data_o  <= rd_en_i ? data_d : '0;
      end
   end

   // R2: read data appears exactly one cycle after the strobe
   p_rd_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_en_i |=> rd_valid_o);
   p_rd_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_en_i |=> (!rd_valid_o && rd_data_o == '0));
endmodule

// File: rtl/dbell_unit.sv
module dbell_unit #(
   parameter int NUM_DB      = 4,
   parameter int NUM_MASTERS = 32,
   parameter int NUM_WP      = 2,
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   localparam int MID_W      = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic [NUM_WP-1:0]           wr_en_i,
   input  logic [NUM_WP*ADDR_W-1:0]    wr_addr_i,
   input  logic [NUM_WP*DATA_W-1:0]    wr_data_i,
   input  logic [NUM_WP*MID_W-1:0]     wr_mid_i,
   input  logic                        rd_en_i,
   input  logic [ADDR_W-1:0]           rd_addr_i,
   output logic [DATA_W-1:0]           rd_data_o,
   output logic                        rd_valid_o,
   output logic [NUM_DB-1:0]           irq_o
);
   import dbu_pkg::*;

   initial begin
      assert (NUM_MASTERS >= 1 && NUM_MASTERS <= 32 && NUM_MASTERS <= DATA_W)
         else $fatal(1, "NUM_MASTERS out of range");
      assert (NUM_DB >= 1 && NUM_DB <= (1 << (ADDR_W - CH_SHIFT)))
         else $fatal(1, "NUM_DB does not fit the address space");
      assert (NUM_WP >= 1) else $fatal(1, "NUM_WP must be at least 1");
   end

   logic [NUM_WP-1:0][NUM_DB-1:0][NUM_MASTERS-1:0] ring_pc, clr_pc;
   logic [NUM_WP-1:0][NUM_DB-1:0]                  en_we_pc;
   logic [NUM_DB-1:0][NUM_MASTERS-1:0]             en_all, raw_all;

   for (genvar p = 0; p < NUM_WP; p++) begin : g_port
      dbu_wdec #(
         .NUM_DB(NUM_DB), .NUM_MASTERS(NUM_MASTERS),
         .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MID_W(MID_W)
      ) u_dec (
         .we_i    (wr_en_i[p]),
         .addr_i  (wr_addr_i[p*ADDR_W +: ADDR_W]),
         .data_i  (wr_data_i[p*DATA_W +: DATA_W]),
         .mid_i   (wr_mid_i[p*MID_W +: MID_W]),
         .ring_o  (ring_pc[p]),
         .clr_o   (clr_pc[p]),
         .en_we_o (en_we_pc[p])
      );
   end

   for (genvar c = 0; c < NUM_DB; c++) begin : g_chan
      logic [NUM_WP-1:0][NUM_MASTERS-1:0] ring_c, clr_c, en_data_c;
      logic [NUM_WP-1:0]                  en_we_c;

      for (genvar p = 0; p < NUM_WP; p++) begin : g_gather
         assign ring_c[p]    = ring_pc[p][c];
         assign clr_c[p]     = clr_pc[p][c];
         assign en_we_c[p]   = en_we_pc[p][c];
         assign en_data_c[p] = wr_data_i[p*DATA_W +: NUM_MASTERS];
      end

      dbu_chan #(.NUM_MASTERS(NUM_MASTERS), .NUM_WP(NUM_WP)) u_chan (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .ring_i    (ring_c),
         .clr_i     (clr_c),
         .en_we_i   (en_we_c),
         .en_data_i (en_data_c),
         .en_o      (en_all[c]),
         .raw_o     (raw_all[c]),
         .irq_o     (irq_o[c])
      );
   end

   dbu_rdmux #(
      .NUM_DB(NUM_DB), .NUM_MASTERS(NUM_MASTERS),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_rd (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rd_en_i    (rd_en_i),
      .rd_addr_i  (rd_addr_i),
      .en_i       (en_all),
      .raw_i      (raw_all),
      .rd_data_o  (rd_data_o),
      .rd_valid_o (rd_valid_o)
   );

   // R10: with no write strobes, no channel state moves
   p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i == '0) |=> ($stable(raw_all) && $stable(en_all)));
endmodule

// File: tb/dbell_unit_tb_top.sv
module dbell_unit_tb_top;
   localparam int NDB = 4;
   localparam int NM  = 32;
   localparam int NWP = 2;
   localparam int AW  = 12;
   localparam int DW  = 32;
   localparam int MW  = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NWP-1:0]    wr_en = '0;
   logic [NWP*AW-1:0] wr_addr = '0;
   logic [NWP*DW-1:0] wr_data = '0;
   logic [NWP*MW-1:0] wr_mid = '0;
   logic              rd_en = 1'b0;
   logic [AW-1:0]     rd_addr = '0;
   logic [DW-1:0]     rd_data;
   logic              rd_valid;
   logic [NDB-1:0]    irq;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [31:0] en_m [NDB];
   logic [31:0] raw_m [NDB];
   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #5 clk = ~clk;

   dbell_unit #(.NUM_DB(NDB), .NUM_MASTERS(NM), .NUM_WP(NWP),
                .ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .wr_mid_i(wr_mid), .rd_en_i(rd_en),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
      .irq_o(irq)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data as results appear
   always @(negedge clk) begin
      if (rd_valid) begin
         if (exp_q.size() == 0) begin
            check("R2 unexpected read data", 32'h1, 32'h0);
         end else begin
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(t, rd_data, e);
         end
      end
   end

   function automatic bit hits(logic [AW-1:0] a, int c, int kind);
      return (int'(a[11:8]) == c) && a[7:4] == 4'h0 && a[1:0] == 2'b00
             && int'(a[3:2]) == kind;
   endfunction

   function automatic logic [31:0] model_read(logic [AW-1:0] a);
      for (int c = 0; c < NDB; c++) begin
         if (hits(a, c, 1)) return en_m[c];
         if (hits(a, c, 2)) return raw_m[c];
         if (hits(a, c, 3)) return raw_m[c] & en_m[c];
      end
      return 32'h0;
   endfunction

   task automatic check_irq(string tag);
      logic [NDB-1:0] e;
      for (int c = 0; c < NDB; c++) e[c] = |(raw_m[c] & en_m[c]);
      check(tag, 32'(irq), 32'(e));
   endtask

   task automatic rd(logic [AW-1:0] a, string tag);
      exp_q.push_back(model_read(a));
      tag_q.push_back(tag);
      rd_addr = a;
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // two-port write; model updated from the requirements
   task automatic wr2(bit v0, logic [AW-1:0] a0, logic [31:0] d0, int m0,
                      bit v1, logic [AW-1:0] a1, logic [31:0] d1, int m1,
                      string tag);
      logic [AW-1:0] aa [2];
      logic [31:0]   dd [2];
      int            mm [2];
      bit            vv [2];
      aa[0] = a0; aa[1] = a1; dd[0] = d0; dd[1] = d1;
      mm[0] = m0; mm[1] = m1; vv[0] = v0; vv[1] = v1;
      wr_en   = {v1, v0};
      wr_addr = {a1, a0};
      wr_data = {d1, d0};
      wr_mid  = {MW'(m1), MW'(m0)};
      @(negedge clk);
      wr_en = '0;
      for (int c = 0; c < NDB; c++) begin
         logic [31:0] ring, clr, en_n;
         ring = '0; clr = '0; en_n = en_m[c];
         for (int p = 1; p >= 0; p--) begin
            if (vv[p]) begin
               if (hits(aa[p], c, 0) && dd[p][0]) ring[mm[p]] = 1'b1;
               if (hits(aa[p], c, 3)) clr |= dd[p];
               if (hits(aa[p], c, 1)) en_n = dd[p];
            end
         end
         raw_m[c] = (raw_m[c] & ~clr) | ring;
         en_m[c]  = en_n;
      end
      check_irq(tag);
   endtask

   task automatic wr(logic [AW-1:0] a, logic [31:0] d, int m, string tag);
      wr2(1'b1, a, d, m, 1'b0, '0, '0, 0, tag);
   endtask

   initial begin
      for (int c = 0; c < NDB; c++) begin en_m[c] = '0; raw_m[c] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check_irq("R1 irq after reset");
      for (int c = 0; c < NDB; c++) begin
         rd(AW'(c*256 + 4), "R1 enable reset");
         rd(AW'(c*256 + 8), "R1 raw reset");
         rd(AW'(c*256 + 12), "R1 pending reset");
      end
      // R3/R4: ring from master 5 to channel 1, not enabled
      wr(12'h100, 32'h1, 5, "R4 disabled ring no irq");
      rd(12'h108, "R4 raw records disabled ring");
      rd(12'h10C, "R4 pending masked");
      // R3: bit0 clear does nothing
      wr(12'h100, 32'h2, 6, "R3 trigger bit0 clear");
      rd(12'h108, "R3 raw unchanged");
      // R6: enable already latched source
      wr(12'h104, 32'h20, 0, "R6 irq on enable");
      rd(12'h10C, "R6 pending visible");
      rd(12'h100, "R2 trigger reads zero");
      rd(12'h110, "R2 bad offset reads zero");
      // R5: irq holds over idle cycles
      repeat (5) @(negedge clk);
      check_irq("R5 irq holds");
      // R7: clear with mixed bits
      wr(12'h100, 32'h1, 9, "R4 second ring");
      wr(12'h10C, 32'h0000_0020, 1, "R7 clear drops irq");
      rd(12'h108, "R7 raw keeps unwritten bit");
      // R5: two sources, clear one
      wr(12'h004, 32'h0000_0003, 2, "R9 enable ch0");
      wr2(1'b1, 12'h000, 32'h1, 0, 1'b1, 12'h000, 32'h1, 1, "R5 two rings");
      wr(12'h00C, 32'h1, 3, "R5 irq stays with one pending");
      wr(12'h00C, 32'h2, 3, "R5 irq falls when all cleared");
      // R8: ring and clear on same bit same cycle
      wr(12'h204, 32'hFFFF_FFFF, 0, "R9 enable all ch2");
      wr(12'h200, 32'h1, 4, "R8 prep ring bit4");
      wr2(1'b1, 12'h200, 32'h1, 3, 1'b1, 12'h20C, 32'h18, 7, "R8 ring vs clear");
      rd(12'h208, "R8 ring wins bit3 bit4 cleared");
      wr2(1'b1, 12'h20C, 32'h8, 7, 1'b1, 12'h200, 32'h1, 3, "R8 swapped ports");
      rd(12'h20C, "R8 ring wins swapped");
      // R9: simultaneous enable writes, port 0 wins
      wr2(1'b1, 12'h304, 32'hA, 0, 1'b1, 12'h304, 32'h5, 1, "R9 dual enable");
      rd(12'h304, "R9 port0 priority");
      // R10: raw writes and unmapped writes ignored
      wr(12'h308, 32'hFFFF_FFFF, 2, "R10 raw write");
      rd(12'h308, "R10 raw unchanged");
      wr(12'h500, 32'h1, 8, "R10 out of range channel");
      wr(12'h240, 32'h1, 8, "R10 bad offset trigger");
      rd(12'h208, "R10 ch2 unchanged");
      rd(12'h500, "R2 unmapped read zero");
      // R3: high master id into enabled channel
      wr(12'h300, 32'h1, 31, "R3 master 31 ring");
      wr(12'h304, 32'h8000_0000, 1, "R6 enable master 31");
      rd(12'h30C, "R3 pending bit31");
      repeat (3) @(negedge clk);
      check("R2 all reads returned", 32'(exp_q.size()), 32'h0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=timeout exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule